// File: doc/BRIEF.md
# Timed Power-Rail Enable Sequencer

This block drives the enable lines of four supply rails: two switching converters and two linear regulators. A single master sequencing input brings the rails up in a timed order and takes them down again. A rising edge on that input starts a power-up run and a falling edge starts a power-down run. Each rail switches after its own delay, measured from the filtered edge. A 3-bit preset code picks the four delays, and the same table serves both directions.

Before any edge is seen, the sequencing input passes through a synchronizer and a 1 ms stability filter. The block counts time with an external 0.5 ms tick, so the 1.5 ms presets come out exact. Each rail's final enable merges a software enable bit with an external per-rail pin and with the rail's sequenced level. An input-supply-OK flag gates all four results, and a bypass bit can override that flag.

Rail bit order on every 4-bit bus: bit 0 = converter 1, bit 1 = converter 2, bit 2 = linear 1, bit 3 = linear 2.

Top module: `pwr_seq_top`

## Requirements
- R1: The sequencing input is synchronized by two flops. Its filtered level changes only after the synchronized level has differed from it on 2 consecutive ticks (1 ms). A pulse that spans fewer ticks is ignored.
- R2: On a rising filtered edge, each rail's sequenced level rises on exactly the D-th tick after the tick of that edge. D is the rail's preset delay in ticks.
- R3: On a falling filtered edge, each rail's sequenced level falls after the same per-rail delay D, taken from the code present at that edge.
- R4: Delays in ticks (0.5 ms) for rails {converter 1, converter 2, linear 1, linear 2}. Code 0: 2,2,2,2. Code 1: 2,3,4,4. Code 2 (the default order): 3,4,6,12. Code 3: 3,4,2,2. Code 4: 3,4,6,12. Code 5: 3,3,4,4. Code 6: 6,4,2,3. Code 7: 4,6,12,22. The code is sampled at the filtered edge.
- R5: rail_en[i] = reg_en[i] AND (ext_en[i] OR sequenced level[i]), gated as in R7. A rail whose reg_en bit is 0 never turns on.
- R6: While a rail's sequenced level is high, changes on ext_en have no effect on that rail.
- R7: While vin_ok is 0 and uvlo_bypass is 0, all rail_en bits are 0. Setting uvlo_bypass restores the R5 result.
- R8: A filtered edge that arrives while timers are still pending aborts them. All four timers restart from zero toward the new level, so an aborted rail never reaches the old level.
- R9: After reset, the filtered level and all sequenced levels are 0, so rail_en equals reg_en AND ext_en (gated as in R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse every 0.5 ms |
| seq_pin | input | 1 | Master sequencing input (asynchronous) |
| ext_en | input | 4 | External per-rail enable pins |
| reg_en | input | 4 | Software per-rail enable bits |
| dly_code | input | 3 | Delay preset code |
| vin_ok | input | 1 | Input supply above lockout threshold |
| uvlo_bypass | input | 1 | Ignore vin_ok when set |
| rail_en | output | 4 | Rail enable outputs |

## Verification
Complete up and down runs use random preset codes and random reg_en masks. The tick on which each rail switches tells apart a wrong table entry, a wrong direction, and a rail that should have been masked. Short pulses on the sequencing input separate a correct 1 ms filter from one that is too short. An opposite edge sent partway through the slowest preset shows whether pending rails are aborted or left to finish. Toggles on ext_en and vin_ok while the sequenced levels are high, and again while they are low, separate the OR term of the enable equation from the gating term.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int NRAIL  = 4;
  localparam int CODE_W = 3;
  localparam int DLY_W  = 5;

  // Preset delays in ticks; word packs {lin2, lin1, cnv2, cnv1}
  function automatic logic [DLY_W-1:0] preset_ticks(input logic [CODE_W-1:0] code,
                                                    input int rail);
    logic [NRAIL*DLY_W-1:0] w;
    case (code)
      3'd0:    w = {5'd2,  5'd2,  5'd2, 5'd2};
      3'd1:    w = {5'd4,  5'd4,  5'd3, 5'd2};
      3'd2:    w = {5'd12, 5'd6,  5'd4, 5'd3};
      3'd3:    w = {5'd2,  5'd2,  5'd4, 5'd3};
      3'd4:    w = {5'd12, 5'd6,  5'd4, 5'd3};
      3'd5:    w = {5'd4,  5'd4,  5'd3, 5'd3};
      3'd6:    w = {5'd3,  5'd2,  5'd4, 5'd6};
      default: w = {5'd22, 5'd12, 5'd6, 5'd4};
    endcase
    return w[rail*DLY_W +: DLY_W];
  endfunction
endpackage

// File: rtl/seq_deglitch.sv
module seq_deglitch #(
  parameter int FILT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_raw,
  output logic sync_lvl,
  output logic filt_lvl,
  output logic flip
);
  localparam int FCNT_W = $clog2(FILT_TICKS + 1);

  logic             s1;
  logic [FCNT_W-1:0] cnt;
  logic             differ;

  assign differ = (sync_lvl != filt_lvl);
  assign flip   = tick && differ && (cnt == FCNT_W'(FILT_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= 1'b0;
      sync_lvl <= 1'b0;
      filt_lvl <= 1'b0;
      cnt      <= '0;
    end else begin
      s1       <= pin_raw;
      sync_lvl <= s1;
      if (!differ) begin
        cnt <= '0;
      end else if (flip) begin
        filt_lvl <= sync_lvl;
        cnt      <= '0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rail_timer.sv
module rail_timer #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             flip,
  input  logic             new_lvl,
  input  logic [DLY_W-1:0] load_val,
  output logic             seq_on,
  output logic             pend
);
  logic [DLY_W-1:0] cnt;
  logic             tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tgt    <= 1'b0;
      pend   <= 1'b0;
      seq_on <= 1'b0;
    end else if (flip) begin
      cnt  <= load_val;
      tgt  <= new_lvl;
      pend <= 1'b1;
    end else if (tick && pend) begin
      if (cnt <= DLY_W'(1)) begin
        seq_on <= tgt;
        pend   <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int FILT_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              seq_pin,
  input  logic [NRAIL-1:0]  ext_en,
  input  logic [NRAIL-1:0]  reg_en,
  input  logic [CODE_W-1:0] dly_code,
  input  logic              vin_ok,
  input  logic              uvlo_bypass,
  output logic [NRAIL-1:0]  rail_en
);
  logic             sync_lvl;
  logic             filt_lvl;
  logic             flip;
  logic [NRAIL-1:0] seq_term;
  logic [NRAIL-1:0] pend;
  logic             supply_gate;

  seq_deglitch #(.FILT_TICKS(FILT_TICKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_raw(seq_pin),
    .sync_lvl(sync_lvl), .filt_lvl(filt_lvl), .flip(flip)
  );

  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    rail_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .flip(flip),
      .new_lvl(sync_lvl), .load_val(preset_ticks(dly_code, i)),
      .seq_on(seq_term[i]), .pend(pend[i])
    );
  end

  assign supply_gate = vin_ok | uvlo_bypass;
  assign rail_en     = reg_en & (ext_en | seq_term) & {NRAIL{supply_gate}};
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       vin_ok,
  input logic       uvlo_bypass,
  input logic [3:0] reg_en,
  input logic [3:0] rail_en,
  input logic       sync_lvl,
  input logic       filt_lvl,
  input logic       flip,
  input logic [3:0] seq_term,
  input logic [3:0] pend
);
  p_filter_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> ($past(tick) && filt_lvl == $past(sync_lvl)));

  p_seq_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_term != $past(seq_term)) |-> $past(tick));

  p_seq_direction_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_term ^ $past(seq_term)) & (seq_term ^ {4{$past(sync_lvl)}})) == 4'b0);

  p_regen_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en & ~reg_en) == 4'b0);

  p_pins_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((&seq_term) && (&$past(seq_term)) && vin_ok && $past(vin_ok) && reg_en == $past(reg_en))
      |-> rail_en == $past(rail_en));

  p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vin_ok && !uvlo_bypass) |-> rail_en == 4'b0);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (&pend));
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .vin_ok(vin_ok),
  .uvlo_bypass(uvlo_bypass), .reg_en(reg_en), .rail_en(rail_en),
  .sync_lvl(sync_lvl), .filt_lvl(filt_lvl), .flip(flip),
  .seq_term(seq_term), .pend(pend)
);

// File: tb/pwr_seq_top_test.sv
`timescale 1ns/1ps
module pwr_seq_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       seq_pin = 1'b0;
  logic [3:0] ext_en = 4'h0;
  logic [3:0] reg_en = 4'hF;
  logic [2:0] dly_code = 3'd2;
  logic       vin_ok = 1'b1;
  logic       uvlo_bypass = 1'b0;
  logic [3:0] rail_en;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_count = 0;
  int div = 0;
  int rise_t[4];
  int fall_t[4];

  always #2.5 clk = ~clk;

  pwr_seq_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .seq_pin(seq_pin),
    .ext_en(ext_en), .reg_en(reg_en), .dly_code(dly_code),
    .vin_ok(vin_ok), .uvlo_bypass(uvlo_bypass), .rail_en(rail_en)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      div  = 0;
      tick = 1'b0;
    end else begin
      tick = (div == 3);
      div  = (div + 1) % 4;
    end
  end

  always @(posedge clk) if (tick) tick_count++;

  // delay in ms*10 restated, converted to 0.5 ms ticks
  function automatic int exp_ticks(input int code, input int rail);
    int ms10[4];
    case (code)
      0: ms10 = '{10, 10, 10, 10};
      1: ms10 = '{10, 15, 20, 20};
      2: ms10 = '{15, 20, 30, 60};
      3: ms10 = '{15, 20, 10, 10};
      4: ms10 = '{15, 20, 30, 60};
      5: ms10 = '{15, 15, 20, 20};
      6: ms10 = '{30, 20, 10, 15};
      default: ms10 = '{20, 30, 60, 110};
    endcase
    return ms10[rail] / 5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic align();
    @(posedge clk iff tick);
    @(negedge clk);
  endtask

  task automatic observe(input int n);
    int base;
    logic [3:0] prev;
    base = tick_count;
    prev = rail_en;
    for (int i = 0; i < 4; i++) begin rise_t[i] = -1; fall_t[i] = -1; end
    while (tick_count - base < n) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (rail_en[i] && !prev[i] && rise_t[i] < 0) rise_t[i] = tick_count - base;
        if (!rail_en[i] && prev[i] && fall_t[i] < 0) fall_t[i] = tick_count - base;
      end
      prev = rail_en;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: reset state
    chk(rail_en == 4'h0, "R9 reset outputs", rail_en, 0);
    ext_en = 4'b1010;
    @(negedge clk);
    chk(rail_en == 4'b1010, "R9 R5 pins pass after reset", rail_en, 4'b1010);
    ext_en = 4'h0;

    // R1: pulse spanning only one tick is filtered out
    align();
    seq_pin = 1'b1;
    repeat (3) @(negedge clk);
    seq_pin = 1'b0;
    observe(30);
    for (int i = 0; i < 4; i++)
      chk(rise_t[i] == -1, "R1 glitch ignored", rise_t[i], -1);

    // R2 R3 R4 R5: random codes and masks
    for (int k = 0; k < 10; k++) begin
      int code;
      logic [3:0] m;
      code = (k == 0) ? 2 : int'($urandom % 8);
      m = (k == 0) ? 4'hF : 4'($urandom % 16);
      reg_en = m;
      dly_code = 3'(code);
      align();
      seq_pin = 1'b1;
      observe(26);
      for (int i = 0; i < 4; i++) begin
        int e;
        e = m[i] ? 2 + exp_ticks(code, i) : -1;
        chk(rise_t[i] == e, "R2 R4 R5 rise tick", rise_t[i], e);
      end
      code = int'($urandom % 8);
      dly_code = 3'(code);
      align();
      seq_pin = 1'b0;
      observe(26);
      for (int i = 0; i < 4; i++) begin
        int e;
        e = m[i] ? 2 + exp_ticks(code, i) : -1;
        chk(fall_t[i] == e, "R3 R4 fall tick", fall_t[i], e);
      end
    end

    // R8: opposite edge aborts pending rails (code 7)
    reg_en = 4'hF;
    dly_code = 3'd7;
    align();
    seq_pin = 1'b1;
    observe(8);
    chk(rise_t[0] == 6, "R8 cnv1 rose before abort", rise_t[0], 6);
    chk(rise_t[1] == 8, "R8 cnv2 rose before abort", rise_t[1], 8);
    seq_pin = 1'b0;
    observe(26);
    chk(rise_t[2] == -1 && rise_t[3] == -1, "R8 lin rails aborted", {rise_t[3] != -1, rise_t[2] != -1}, 0);
    chk(fall_t[0] == 6, "R8 cnv1 fall restart", fall_t[0], 6);
    chk(fall_t[1] == 8, "R8 cnv2 fall restart", fall_t[1], 8);
    chk(rail_en == 4'h0, "R8 all off", rail_en, 0);

    // R6 R7: bring all rails up, then toggle pins and supply
    dly_code = 3'd0;
    align();
    seq_pin = 1'b1;
    observe(8);
    chk(rail_en == 4'hF, "R2 all on", rail_en, 4'hF);
    for (int k = 0; k < 6; k++) begin
      ext_en = 4'($urandom % 16);
      @(negedge clk);
      chk(rail_en == 4'hF, "R6 pins ignored", rail_en, 4'hF);
    end
    vin_ok = 1'b0;
    @(negedge clk);
    chk(rail_en == 4'h0, "R7 lockout", rail_en, 0);
    uvlo_bypass = 1'b1;
    @(negedge clk);
    chk(rail_en == 4'hF, "R7 bypass", rail_en, 4'hF);
    uvlo_bypass = 1'b0;
    @(negedge clk);
    chk(rail_en == 4'h0, "R7 lockout again", rail_en, 0);
    vin_ok = 1'b1;

    // R5: sequence low, pins decide
    align();
    seq_pin = 1'b0;
    observe(8);
    for (int k = 0; k < 6; k++) begin
      logic [3:0] p, r;
      p = 4'($urandom % 16);
      r = 4'($urandom % 16);
      ext_en = p;
      reg_en = r;
      @(negedge clk);
      chk(rail_en == (p & r), "R5 equation", rail_en, p & r);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule